// File: doc/BRIEF.md
# Sector Page-Load and Program Sequencer

This block models the write path of a byte-wide nonvolatile memory that is rewritten one whole sector at a time. An external agent drives an asynchronous-style bus made of active-low chip-enable, output-enable and write-enable strobes, an address and a data byte. The block samples that bus on its own clock. Each qualified write strobe deposits one byte into a 256-byte page buffer. The bytes may arrive in any order. The first accepted byte fixes which sector the page belongs to.

When no further strobe begins within a programmable load window, the page is closed. An internal period then starts: the whole target sector is first erased to all ones, a programmable hold time elapses, and the buffered bytes are copied into the array. Bytes that were never loaded keep the erased value, and a flag reports that this happened. A busy output covers the whole internal period.

After reset, a boot lockout sets the array to all ones and refuses writes for a programmable number of cycles. Reads are combinational from the array and are presented only when the bus asks for a read.

Top module: `spl_sector_prog`

## Requirements
- R1: A byte load is accepted only when we_n and ce_n are both low while oe_n is high, and that condition persists for at least FILT_CYC sampled clock cycles. A shorter pulse, or a strobe with oe_n low, changes nothing in the array and does not raise busy.
- R2: The address of a load is taken when the strobe becomes qualified. The data is the last value present while the strobe was still active. Changing addr late in the pulse does not redirect the byte, and a late change of din is what gets stored.
- R3: addr[7:0] selects the byte within a sector and the bits above select the sector. The bytes of a sector may be loaded in any order, and each lands at its own offset.
- R4: Programming begins once WIN_TICKS cycles pass after the end of the last load with no new load starting. Every accepted load in the same sector restarts that wait, so closely spaced loads never raise busy between them.
- R5: The internal period erases every byte of the target sector to 8'hFF and then writes each loaded byte. Unloaded bytes read 8'hFF afterwards. gap_fill is 1 after a period in which at least one of the 256 bytes was not loaded, and 0 after a fully loaded sector.
- R6: busy rises at the window timeout and stays high for 256 erase cycles, PGM_TICKS hold cycles and 256 program cycles. Loads that start while busy is high are ignored.
- R7: A load whose sector differs from the sector of the page's first accepted byte is ignored. That sector is left unchanged.
- R8: For max(BOOT_TICKS, array depth) cycles after reset, loads are ignored, busy stays low, and the array is set to 8'hFF.
- R9: dout_en equals (ce_n low AND oe_n low AND we_n high) for all eight strobe combinations. dout shows the array byte at addr while not busy, and 8'h00 while busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | SECT_W+8 | Byte address: sector number above, in-sector offset in bits 7:0 |
| din | input | 8 | Write data byte |
| dout | output | 8 | Read data byte |
| dout_en | output | 1 | High when the bus requests a read; drives the data pads |
| busy | output | 1 | Internal erase/program period in progress |
| gap_fill | output | 1 | Last program period left at least one byte unloaded |

## Verification
The assertions assume that addr and din stay stable through the sampled edges of a strobe and that the strobe pins are released between loads, so that every qualified start is paired with exactly one end. They also assume that each load window contains at most one in-flight strobe. The stimulus drives every pin on the falling clock edge. It holds address and data across each pulse, except in the one deliberate late-change case, and leaves at least two idle cycles between pulses. Glitch and inhibit cases are single pulses surrounded by idle bus time, which keeps the sampled strobe history free of overlapping loads.

// File: rtl/spl_pkg.sv
package spl_pkg;

    localparam int BYTE_W     = 8;
    localparam int OFS_W      = 8;
    localparam int SECT_BYTES = 1 << OFS_W;

    localparam logic [BYTE_W-1:0] FILL_BYTE = '1;

    typedef enum logic [2:0] {
        ST_LOCK,
        ST_IDLE,
        ST_LOAD,
        ST_ERASE,
        ST_HOLD,
        ST_PROG
    } seq_st_t;

    // One qualified strobe: start carries the offset, stop carries the data
    typedef struct packed {
        logic              start;
        logic              stop;
        logic [OFS_W-1:0]  ofs;
        logic [BYTE_W-1:0] data;
    } ld_evt_t;

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/spl_strobe_qual.sv
module spl_strobe_qual
    import spl_pkg::*;
#(
    parameter int SECT_W   = 3,
    parameter int FILT_CYC = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ce_n,
    input  logic                    oe_n,
    input  logic                    we_n,
    input  logic [SECT_W+OFS_W-1:0] addr,
    input  logic [BYTE_W-1:0]       din,
    output ld_evt_t                 evt,
    output logic [SECT_W-1:0]       evt_sect
);

    localparam int AW = SECT_W + OFS_W;
    localparam int RW = $clog2(FILT_CYC + 1);

    logic              act_raw;
    logic [1:0]        act_q;
    logic [AW-1:0]     a_q1, a_q2;
    logic [BYTE_W-1:0] d_q1, d_q2, d_last;
    logic [RW-1:0]     run;
    logic              armed;

    assign act_raw = ~ce_n & ~we_n & oe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q    <= '0;
            a_q1     <= '0;
            a_q2     <= '0;
            d_q1     <= '0;
            d_q2     <= '0;
            d_last   <= '0;
            run      <= '0;
            armed    <= 1'b0;
            evt      <= '0;
            evt_sect <= '0;
        end else begin
            act_q     <= {act_q[0], act_raw};
            a_q1      <= addr;
            a_q2      <= a_q1;
            d_q1      <= din;
            d_q2      <= d_q1;
            evt.start <= 1'b0;
            evt.stop  <= 1'b0;
            if (act_q[1]) begin
                d_last <= d_q2;
                if (!armed) begin
                    if (run == RW'(FILT_CYC - 1)) begin
                        armed     <= 1'b1;
                        evt.start <= 1'b1;
                        evt.ofs   <= a_q2[OFS_W-1:0];
                        evt_sect  <= a_q2[AW-1:OFS_W];
                    end else begin
                        run <= run + 1'b1;
                    end
                end
            end else begin
                run <= '0;
                if (armed) begin
                    armed    <= 1'b0;
                    evt.stop <= 1'b1;
                    evt.data <= d_last;
                end
            end
        end
    end

    AST_START_FROM_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        evt.start |-> $past(act_q[1])) else $error("start without active strobe"); // R1
    AST_NO_BACK_TO_BACK_START: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> !evt.start) else $error("double start"); // R1

endmodule

// File: rtl/spl_sector_buf.sv
module spl_sector_buf
    import spl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  wr_ofs,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              clr,
    input  logic [OFS_W-1:0]  rd_ofs,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_vld,
    output logic              all_vld
);

    logic [BYTE_W-1:0]     bytes_q [SECT_BYTES];
    logic [SECT_BYTES-1:0] vld_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            bytes_q[wr_ofs] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_ofs] <= 1'b1;
        end
    end

    assign rd_data = bytes_q[rd_ofs];
    assign rd_vld  = vld_q[rd_ofs];
    assign all_vld = &vld_q;

    AST_CLR_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(clr && wr_en)) else $error("buffer write during clear"); // R6

endmodule

// File: rtl/spl_byte_array.sv
module spl_byte_array
    import spl_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [BYTE_W-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/spl_prog_seq.sv
module spl_prog_seq
    import spl_pkg::*;
#(
    parameter int SECT_W     = 3,
    parameter int WIN_TICKS  = 18750,
    parameter int PGM_TICKS  = 1250000,
    parameter int BOOT_TICKS = 625000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  ld_evt_t                 evt,
    input  logic [SECT_W-1:0]       evt_sect,
    output logic                    buf_we,
    output logic [OFS_W-1:0]        buf_wr_ofs,
    output logic [BYTE_W-1:0]       buf_wr_data,
    output logic                    buf_clr,
    output logic [OFS_W-1:0]        buf_rd_ofs,
    input  logic [BYTE_W-1:0]       buf_rd_data,
    input  logic                    buf_rd_vld,
    input  logic                    buf_all_vld,
    output logic                    mem_we,
    output logic [SECT_W+OFS_W-1:0] mem_waddr,
    output logic [BYTE_W-1:0]       mem_wdata,
    output logic                    busy,
    output logic                    locked,
    output logic                    gap_fill
);

    localparam int AW       = SECT_W + OFS_W;
    localparam int DEPTH    = 1 << AW;
    localparam int LOCK_LEN = int'(umax(BOOT_TICKS, DEPTH));
    localparam int CNT_TOP  = int'(umax(umax(LOCK_LEN, PGM_TICKS),
                                        umax(WIN_TICKS, SECT_BYTES)));
    localparam int CW       = $clog2(CNT_TOP + 1);

    seq_st_t           st;
    logic [CW-1:0]     cnt;
    logic [SECT_W-1:0] sect_q;
    logic              pend;
    logic [OFS_W-1:0]  pend_ofs;
    logic              last_byte;

    assign last_byte   = (cnt == CW'(SECT_BYTES - 1));
    assign buf_wr_ofs  = pend_ofs;
    assign buf_wr_data = evt.data;
    assign buf_rd_ofs  = cnt[OFS_W-1:0];
    assign busy        = (st == ST_ERASE) || (st == ST_HOLD) || (st == ST_PROG);
    assign locked      = (st == ST_LOCK);

    always_comb begin
        buf_we    = 1'b0;
        buf_clr   = 1'b0;
        mem_we    = 1'b0;
        mem_waddr = {sect_q, cnt[OFS_W-1:0]};
        mem_wdata = FILL_BYTE;
        case (st)
            ST_LOCK: begin
                mem_we    = (cnt < CW'(DEPTH));
                mem_waddr = cnt[AW-1:0];
            end
            ST_LOAD:  buf_we = evt.stop && pend;
            ST_ERASE: mem_we = 1'b1;
            ST_PROG: begin
                mem_we    = 1'b1;
                mem_wdata = buf_rd_vld ? buf_rd_data : FILL_BYTE;
                buf_clr   = last_byte;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_LOCK;
            cnt      <= '0;
            sect_q   <= '0;
            pend     <= 1'b0;
            pend_ofs <= '0;
            gap_fill <= 1'b0;
        end else begin
            case (st)
                ST_LOCK: begin
                    if (cnt == CW'(LOCK_LEN - 1)) begin
                        st  <= ST_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (evt.start) begin
                        sect_q   <= evt_sect;
                        pend     <= 1'b1;
                        pend_ofs <= evt.ofs;
                        cnt      <= '0;
                        st       <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (evt.start && (evt_sect == sect_q)) begin
                        pend     <= 1'b1;
                        pend_ofs <= evt.ofs;
                        cnt      <= '0;
                    end else if (evt.stop && pend) begin
                        pend <= 1'b0;
                        cnt  <= '0;
                    end else if (!pend) begin
                        if (cnt == CW'(WIN_TICKS - 1)) begin
                            st       <= ST_ERASE;
                            cnt      <= '0;
                            gap_fill <= !buf_all_vld;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_ERASE: begin
                    cnt <= last_byte ? '0 : cnt + 1'b1;
                    if (last_byte) st <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (cnt == CW'(PGM_TICKS - 1)) begin
                        st  <= ST_PROG;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PROG: begin
                    cnt <= last_byte ? '0 : cnt + 1'b1;
                    if (last_byte) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_LOCK_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        locked |-> !buf_we) else $error("load during lockout"); // R8
    AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        busy |-> !buf_we) else $error("load while busy"); // R6
    AST_SECT_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(sect_q)) else $error("sector moved"); // R7
    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LOAD && !pend) |-> (cnt < CW'(WIN_TICKS))) else $error("window overrun"); // R4

endmodule

// File: rtl/spl_sector_prog.sv
module spl_sector_prog
    import spl_pkg::*;
#(
    parameter int SECT_W     = 3,
    parameter int FILT_CYC   = 2,
    parameter int WIN_TICKS  = 18750,
    parameter int PGM_TICKS  = 1250000,
    parameter int BOOT_TICKS = 625000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ce_n,
    input  logic                    oe_n,
    input  logic                    we_n,
    input  logic [SECT_W+OFS_W-1:0] addr,
    input  logic [BYTE_W-1:0]       din,
    output logic [BYTE_W-1:0]       dout,
    output logic                    dout_en,
    output logic                    busy,
    output logic                    gap_fill
);

    localparam int AW = SECT_W + OFS_W;

    ld_evt_t           evt;
    logic [SECT_W-1:0] evt_sect;
    logic              buf_we, buf_clr, buf_rd_vld, buf_all_vld;
    logic [OFS_W-1:0]  buf_wr_ofs, buf_rd_ofs;
    logic [BYTE_W-1:0] buf_wr_data, buf_rd_data;
    logic              mem_we, locked;
    logic [AW-1:0]     mem_waddr;
    logic [BYTE_W-1:0] mem_wdata, arr_rdata;

    spl_strobe_qual #(.SECT_W(SECT_W), .FILT_CYC(FILT_CYC)) qual_i (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .evt(evt), .evt_sect(evt_sect)
    );

    spl_sector_buf buf_i (
        .clk(clk), .rst(rst), .wr_en(buf_we), .wr_ofs(buf_wr_ofs),
        .wr_data(buf_wr_data), .clr(buf_clr), .rd_ofs(buf_rd_ofs),
        .rd_data(buf_rd_data), .rd_vld(buf_rd_vld), .all_vld(buf_all_vld)
    );

    spl_prog_seq #(
        .SECT_W(SECT_W), .WIN_TICKS(WIN_TICKS),
        .PGM_TICKS(PGM_TICKS), .BOOT_TICKS(BOOT_TICKS)
    ) seq_i (
        .clk(clk), .rst(rst), .evt(evt), .evt_sect(evt_sect),
        .buf_we(buf_we), .buf_wr_ofs(buf_wr_ofs), .buf_wr_data(buf_wr_data),
        .buf_clr(buf_clr), .buf_rd_ofs(buf_rd_ofs), .buf_rd_data(buf_rd_data),
        .buf_rd_vld(buf_rd_vld), .buf_all_vld(buf_all_vld),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .busy(busy), .locked(locked), .gap_fill(gap_fill)
    );

    spl_byte_array #(.AW(AW)) arr_i (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(addr), .rdata(arr_rdata)
    );

    assign dout_en = ~ce_n & ~oe_n & we_n;
    assign dout    = busy ? '0 : arr_rdata;

    AST_ARRAY_WR_INTERNAL: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (busy || locked)) else $error("array write outside period"); // R5
    AST_NO_BUSY_IN_LOCK: assert property (@(posedge clk) disable iff (rst)
        locked |-> !busy) else $error("busy during lockout"); // R8

endmodule

// File: tb/spl_sector_prog_tb.sv
`timescale 1ns/1ps
module spl_sector_prog_tb_top;

    localparam int SECT_W = 2;
    localparam int AW     = SECT_W + 8;
    localparam int DEPTH  = 1 << AW;
    localparam int WIN    = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic dout_en, busy, gap_fill;

    int checks = 0;
    int errors = 0;
    int busy_rises = 0;
    logic busy_d = 1'b0;
    logic [7:0] model [DEPTH];

    always #4 clk = ~clk;

    spl_sector_prog #(
        .SECT_W(SECT_W), .FILT_CYC(2), .WIN_TICKS(WIN),
        .PGM_TICKS(30), .BOOT_TICKS(1100)
    ) dut_i (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .busy(busy), .gap_fill(gap_fill)
    );

    always @(posedge clk) begin
        busy_d <= busy;
        if (busy && !busy_d) busy_rises <= busy_rises + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input int a, input int d, input int lo);
        @(negedge clk);
        addr = AW'(a); din = 8'(d); oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        tick(lo);
        we_n = 1'b1; ce_n = 1'b1;
        tick(2);
    endtask

    task automatic rd(input int a, input string req);
        @(negedge clk);
        addr = AW'(a); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #1;
        check(dout === model[a], req, int'(dout), int'(model[a]));
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < DEPTH; a++) rd(a, req);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wait_prog(input string req);
        int n = 0;
        while (busy !== 1'b1 && n < 80) begin tick(1); n++; end
        check(busy === 1'b1, req, int'(busy), 1);
        n = 0;
        while (busy !== 1'b0 && n < 1000) begin tick(1); n++; end
        check(busy === 1'b0, req, int'(busy), 0);
        tick(2);
    endtask

    function automatic int sect_base(input int s);
        return s << 8;
    endfunction

    initial begin
        #1200000;
        checks++; errors++;
        $display("FAIL R0: watchdog expired, actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int rises0;
        for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
        tick(3);
        // reset state
        check(busy === 1'b0, "R6 reset busy", int'(busy), 0);
        check(dout_en === 1'b0, "R9 reset dout_en", int'(dout_en), 0);
        rst = 1'b0;

        // R8: load during lockout ignored, array cleared
        tick(20);
        load(sect_base(1), 8'h77, 4);
        tick(1150);
        check(busy_rises == 0, "R8 lockout load", busy_rises, 0);
        sweep("R8 boot fill");

        // R3/R4/R5/R6/R9: full sector 1 loaded in reverse order
        for (int i = 255; i >= 0; i--) begin
            load(sect_base(1) + i, (i * 7 + 3) & 8'hFF, 4);
            model[sect_base(1) + i] = 8'((i * 7 + 3) & 8'hFF);
        end
        tick(15);
        check(busy === 1'b0, "R4 busy inside window", int'(busy), 0);
        tick(15);
        check(busy === 1'b1, "R4 busy after window", int'(busy), 1);
        @(negedge clk);
        addr = AW'(sect_base(1) + 9); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #1;
        check(dout === 8'h00, "R9 dout quiet while busy", int'(dout), 0);
        ce_n = 1'b1; oe_n = 1'b1;
        load(sect_base(1), 8'h00, 4);   // R6: ignored while busy
        tick(100);
        check(busy === 1'b1, "R6 busy holds", int'(busy), 1);
        wait_prog("R6 period ends");
        check(gap_fill === 1'b0, "R5 full sector no gap", int'(gap_fill), 0);
        check(busy_rises == 1, "R6 single period", busy_rises, 1);
        sweep("R3 full sector readback");

        // R2/R5: partial sector 2, plus late address/data change
        for (int i = 0; i <= 20; i += 2) begin
            load(sect_base(2) + i, i ^ 8'h5A, 4);
            model[sect_base(2) + i] = 8'(i ^ 8'h5A);
        end
        @(negedge clk);
        addr = AW'(sect_base(2) + 100); din = 8'h11; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        tick(6);
        addr = AW'(sect_base(2) + 101); din = 8'h3C;
        tick(2);
        we_n = 1'b1; ce_n = 1'b1;
        model[sect_base(2) + 100] = 8'h3C;
        tick(2);
        wait_prog("R4 partial period");
        check(gap_fill === 1'b1, "R5 gap flag", int'(gap_fill), 1);
        rd(sect_base(2) + 100, "R2 late data stored");
        rd(sect_base(2) + 101, "R2 late address ignored");
        sweep("R5 partial readback");

        // R5: reprogram sector 1 with one byte, rest erased
        load(sect_base(1) + 7, 8'h42, 4);
        for (int i = 0; i < 256; i++) model[sect_base(1) + i] = 8'hFF;
        model[sect_base(1) + 7] = 8'h42;
        wait_prog("R5 reprogram period");
        sweep("R5 erase before program");

        // R7: foreign sector load ignored
        load(sect_base(3) + 5, 8'hAA, 4);
        load(sect_base(0) + 5, 8'h55, 4);
        load(sect_base(3) + 6, 8'hBB, 4);
        model[sect_base(3) + 5] = 8'hAA;
        model[sect_base(3) + 6] = 8'hBB;
        wait_prog("R7 period");
        rd(sect_base(0) + 5, "R7 foreign sector untouched");
        rd(sect_base(3) + 5, "R7 first byte");
        rd(sect_base(3) + 6, "R7 same sector byte");

        // R1: short pulse and oe-inhibited strobe
        rises0 = busy_rises;
        load(sect_base(0) + 9, 8'h01, 1);
        @(negedge clk);
        addr = AW'(sect_base(0) + 9); din = 8'h02; oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
        tick(4);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        tick(60);
        check(busy_rises == rises0, "R1 glitch and oe inhibit", busy_rises, rises0);
        rd(sect_base(0) + 9, "R1 byte unchanged");

        // R4: spaced loads restart the window
        rises0 = busy_rises;
        for (int i = 10; i < 13; i++) begin
            load(sect_base(0) + i, 8'h10 + i, 4);
            tick(13);
        end
        check(busy_rises == rises0, "R4 window restart", busy_rises, rises0);
        for (int i = 0; i < 256; i++) model[sect_base(0) + i] = 8'hFF;
        for (int i = 10; i < 13; i++) model[sect_base(0) + i] = 8'(8'h10 + i);
        wait_prog("R4 restart period");
        sweep("R4 restart readback");

        // R9: output enable over all strobe combinations
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            ce_n = k[2]; oe_n = k[1]; we_n = k[0];
            #1;
            check(dout_en === (!k[2] && !k[1] && k[0]), "R9 dout_en combo",
                  int'(dout_en), int'(!k[2] && !k[1] && k[0]));
        end
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        tick(60);
        check(busy_rises == rises0 + 1, "R1 combo pulses ignored", busy_rises, rises0 + 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule